// File: doc/BRIEF.md
# PCI Inbound Memory-Write Target

This block is the slave-side front end that accepts PCI memory writes aimed at a local memory window. In the address phase it compares the page number of the address against a base page and a limit page. It checks that the address queue can take an entry and that the data queue has at least one free slot. If all of that holds, it claims the cycle. It then absorbs one data phase on every clock where the initiator drives IRDY#, and it pushes each beat into a posted-write data queue. Because it never holds TRDY# high while claimed, it inserts no wait states.

A burst ends in one of two ways. The initiator may complete it by raising FRAME# on its last phase. Or a beat may take the last free data-queue slot, and then the target signals a Disconnect and returns to idle. In both cases a single address-queue entry follows the final beat. That entry carries the translated local address, the byte count and the bus width used. Data phases are 64-bit when REQ64# was asserted in the address phase and 32-bit otherwise. The block checks parity on the address and on every data beat. A data parity error only raises PERR# and an event pulse, and the write goes on. An address parity error raises its own event and the target stays off the bus.

This bus model is simplified. PAR and PAR64 accompany the address or data they cover in the same clock, and output enables are not modelled.

Back-pressure works as follows. The data queue has no ready signal. Instead, `dq_space` reports its free slots after all earlier pushes, and the target consumes them without waiting. The address queue uses `aq_valid`/`aq_ready`. `aq_ready` is sampled at the claim, and once it is high the sink must keep it high until it takes the next push.

Top module: `pci_inwr_target`

## Requirements
- R1: A cycle is claimed only when the command on C/BE[3:0]# is 4'b0111 (memory write) and base_page <= AD[31:12] <= limit_page, with both bounds inclusive. A claim shows as DEVSEL# and TRDY# low in the clock after the address phase.
- R2: There is no claim, and no push of any kind, when `aq_ready` is low or `dq_space` is zero at the address phase.
- R3: While claimed, and before a Disconnect, TRDY# stays low. Every clock with IRDY# low pushes exactly one beat into the data queue in that same clock, and a clock with IRDY# high pushes nothing.
- R4: With REQ64# low at the address phase, ACK64# goes low together with DEVSEL#, and each beat carries all 64 data bits with byte enables = ~C/BE[7:0]#. Otherwise the upper 32 data bits and the upper 4 enables are pushed as zero.
- R5: A beat taken while FRAME# is low and `dq_space` is 1 causes a Disconnect. In the next clock STOP# is low and TRDY# is high. STOP# and DEVSEL# stay low until FRAME# has been sampled high.
- R6: A beat taken with FRAME# high completes the burst. In the next clock DEVSEL#, TRDY# and STOP# are all high.
- R7: Exactly one address-queue push follows each claimed burst, in the clock after its final beat. It carries local address = address - base_page*4096 + local offset, byte count = beats * (8 if 64-bit, else 4), and the width flag.
- R8: A data beat with bad even parity (AD[31:0], C/BE[3:0]#, PAR; and for 64-bit beats also AD[63:32], C/BE[7:4]#, PAR64) drives PERR# low and pulses `dpe_evt` in the next clock. The beat is still pushed and the burst continues.
- R9: An address phase with bad even parity over AD[31:0], C/BE[3:0]# and PAR pulses `ape_evt` in the next clock, and the cycle is not claimed.
- R10: After reset, and whenever the bus is idle, DEVSEL#, TRDY#, STOP#, ACK64# and PERR# are high and neither queue receives a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| pci_frame_n | input | 1 | Cycle framing from initiator |
| pci_irdy_n | input | 1 | Initiator ready |
| pci_req64_n | input | 1 | Initiator requests 64-bit transfer |
| pci_ad | input | 64 | Address/data bus |
| pci_cbe_n | input | 8 | Command / byte enables, active low |
| pci_par | input | 1 | Even parity for lower half |
| pci_par64 | input | 1 | Even parity for upper half |
| pci_devsel_n | output | 1 | Target claims cycle |
| pci_trdy_n | output | 1 | Target ready |
| pci_stop_n | output | 1 | Target requests stop (Disconnect) |
| pci_ack64_n | output | 1 | Target accepts 64-bit transfer |
| pci_perr_n | output | 1 | Data parity error report |
| win_base_pg | input | 20 | First page of window |
| win_limit_pg | input | 20 | Last page of window (inclusive) |
| loc_offset | input | 32 | Local base added to window offset |
| aq_valid | output | 1 | Address entry push |
| aq_ready | input | 1 | Address queue can take an entry |
| aq_addr | output | 32 | Translated local address |
| aq_bytes | output | 12 | Bytes in burst |
| aq_wide | output | 1 | Burst used 64-bit beats |
| dq_valid | output | 1 | Data beat push |
| dq_data | output | 64 | Beat data |
| dq_be | output | 8 | Beat byte enables, active high |
| dq_space | input | 5 | Free data-queue slots |
| ape_evt | output | 1 | Address parity error pulse |
| dpe_evt | output | 1 | Data parity error pulse |

## Verification
The bench targets several window edges: the first byte of the base page, the last word of the limit page, and the pages just outside them on each side. A comparator with the wrong bound would claim foreign cycles or drop valid ones. It pits a burst whose length equals the free space against one longer by a beat, so that an off-by-one in the fill test shows up as a spurious STOP#, as a write past the last slot, or as a wrong byte count. Bursts are mixed with random IRDY# waits and bad-parity beats. A design that stalled on parity, pushed on wait clocks or leaked upper lanes in 32-bit mode produces beats that differ from the bench's expected values. Address-phase parity errors and missing queue space are aimed at claims that should never happen.

// File: rtl/pcitw_pkg.sv
package pcitw_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_XFER  = 2'd1,
    TS_STOP  = 2'd2,
    TS_DRAIN = 2'd3
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
endpackage

// File: rtl/pcitw_window.sv
module pcitw_window #(
  parameter int AW     = 32,
  parameter int PG_LSB = 12,
  localparam int PG_W  = AW - PG_LSB
) (
  input  logic [AW-1:0]   addr,
  input  logic [PG_W-1:0] base_pg,
  input  logic [PG_W-1:0] limit_pg,
  input  logic [AW-1:0]   loc_off,
  output logic            hit,
  output logic [AW-1:0]   xlat
);
  logic [PG_W-1:0] pg;
  logic [AW-1:0]   base_byte;

  assign pg        = addr[AW-1:PG_LSB];
  assign base_byte = {base_pg, {PG_LSB{1'b0}}};
  assign hit       = (pg >= base_pg) && (pg <= limit_pg);
  assign xlat      = addr - base_byte + loc_off;
endmodule

// File: rtl/pcitw_parity.sv
module pcitw_parity #(
  parameter int DW    = 64,
  localparam int HW   = DW / 2,
  localparam int BE_W = DW / 8,
  localparam int HBE  = BE_W / 2
) (
  input  logic [DW-1:0]   ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            par_lo,
  input  logic            par_hi,
  output logic [1:0]      lane_bad
);
  logic [1:0] par_v;
  assign par_v = {par_hi, par_lo};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_bad[g] = ^{ad[g*HW +: HW], cbe_n[g*HBE +: HBE], par_v[g]};
  end
endmodule

// File: rtl/pcitw_ctrl.sv
module pcitw_ctrl
  import pcitw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BC_W  = 12,
  parameter int SPC_W = 5,
  localparam int HW   = DW / 2,
  localparam int BE_W = DW / 8,
  localparam int HBE  = BE_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             req64_n,
  input  logic [DW-1:0]    ad,
  input  logic [BE_W-1:0]  cbe_n,
  input  logic             hit,
  input  logic [AW-1:0]    xlat,
  input  logic [1:0]       lane_bad,
  input  logic             aq_ready,
  input  logic [SPC_W-1:0] dq_space,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ack64_n,
  output logic             perr_n,
  output logic             ape_evt,
  output logic             dpe_evt,
  output logic             aq_valid,
  output logic [AW-1:0]    aq_addr,
  output logic [BC_W-1:0]  aq_bytes,
  output logic             aq_wide,
  output logic             dq_valid,
  output logic [DW-1:0]    dq_data,
  output logic [BE_W-1:0]  dq_be
);
  tgt_state_e      st_q, st_d;
  logic            wide_q;
  logic [BC_W-1:0] beats_q;
  logic [AW-1:0]   addr_q;

  logic addr_phase, claim, xfer, last_beat, fill_beat, done;
  logic apar_bad, dbeat_bad;
  logic sel_low, trdy_low, stop_low, wide_nxt;
  logic [BC_W-1:0] beats_nxt, bytes_nxt;

  assign apar_bad   = lane_bad[0];
  assign dbeat_bad  = lane_bad[0] | (wide_q & lane_bad[1]);
  assign addr_phase = (st_q == TS_IDLE) && !frame_n;
  assign claim      = addr_phase && (cbe_n[3:0] == CMD_MEM_WRITE) && hit &&
                      !apar_bad && aq_ready && (dq_space != '0);
  assign xfer       = (st_q == TS_XFER) && !irdy_n;
  assign last_beat  = xfer && frame_n;
  assign fill_beat  = xfer && !frame_n && (dq_space == SPC_W'(1));
  assign done       = last_beat || fill_beat;
  assign beats_nxt  = beats_q + BC_W'(1);
  assign bytes_nxt  = wide_q ? {beats_nxt[BC_W-4:0], 3'b000}
                             : {beats_nxt[BC_W-3:0], 2'b00};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_IDLE:  if (claim) st_d = TS_XFER;
                else if (addr_phase) st_d = TS_DRAIN;
      TS_XFER:  if (last_beat) st_d = TS_IDLE;
                else if (fill_beat) st_d = TS_STOP;
      TS_STOP:  if (frame_n) st_d = TS_DRAIN;
      TS_DRAIN: if (frame_n && irdy_n) st_d = TS_IDLE;
      default:  st_d = TS_IDLE;
    endcase
  end

  assign sel_low  = claim || ((st_q == TS_XFER) && !last_beat) ||
                    ((st_q == TS_STOP) && !frame_n);
  assign trdy_low = claim || ((st_q == TS_XFER) && !done);
  assign stop_low = fill_beat || ((st_q == TS_STOP) && !frame_n);
  assign wide_nxt = claim ? !req64_n : wide_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= TS_IDLE;
      wide_q   <= 1'b0;
      beats_q  <= '0;
      addr_q   <= '0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ack64_n  <= 1'b1;
      perr_n   <= 1'b1;
      ape_evt  <= 1'b0;
      dpe_evt  <= 1'b0;
      aq_valid <= 1'b0;
      aq_addr  <= '0;
      aq_bytes <= '0;
      aq_wide  <= 1'b0;
    end else begin
      st_q     <= st_d;
      devsel_n <= !sel_low;
      trdy_n   <= !trdy_low;
      stop_n   <= !stop_low;
      ack64_n  <= !(sel_low && wide_nxt);
      perr_n   <= !(xfer && dbeat_bad);
      dpe_evt  <= xfer && dbeat_bad;
      ape_evt  <= addr_phase && apar_bad;
      aq_valid <= done;
      if (claim) begin
        addr_q  <= xlat;
        wide_q  <= !req64_n;
        beats_q <= '0;
      end else if (xfer) begin
        beats_q <= beats_nxt;
      end
      if (done) begin
        aq_addr  <= addr_q;
        aq_bytes <= bytes_nxt;
        aq_wide  <= wide_q;
      end
    end
  end

  assign dq_valid = xfer;
  for (genvar g = 0; g < 2; g++) begin : g_half
    logic keep;
    assign keep = (g == 0) || wide_q;
    assign dq_data[g*HW +: HW]  = keep ? ad[g*HW +: HW] : '0;
    assign dq_be[g*HBE +: HBE]  = keep ? ~cbe_n[g*HBE +: HBE] : '0;
  end
endmodule

// File: rtl/pci_inwr_target.sv
module pci_inwr_target #(
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int PG_LSB = 12,
  parameter int BC_W   = 12,
  parameter int SPC_W  = 5,
  localparam int PG_W  = AW - PG_LSB,
  localparam int BE_W  = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pci_frame_n,
  input  logic             pci_irdy_n,
  input  logic             pci_req64_n,
  input  logic [DW-1:0]    pci_ad,
  input  logic [BE_W-1:0]  pci_cbe_n,
  input  logic             pci_par,
  input  logic             pci_par64,
  output logic             pci_devsel_n,
  output logic             pci_trdy_n,
  output logic             pci_stop_n,
  output logic             pci_ack64_n,
  output logic             pci_perr_n,
  input  logic [PG_W-1:0]  win_base_pg,
  input  logic [PG_W-1:0]  win_limit_pg,
  input  logic [AW-1:0]    loc_offset,
  output logic             aq_valid,
  input  logic             aq_ready,
  output logic [AW-1:0]    aq_addr,
  output logic [BC_W-1:0]  aq_bytes,
  output logic             aq_wide,
  output logic             dq_valid,
  output logic [DW-1:0]    dq_data,
  output logic [BE_W-1:0]  dq_be,
  input  logic [SPC_W-1:0] dq_space,
  output logic             ape_evt,
  output logic             dpe_evt
);
  logic          win_hit;
  logic [AW-1:0] win_xlat;
  logic [1:0]    lane_bad;

  pcitw_window #(.AW(AW), .PG_LSB(PG_LSB)) win_u (
    .addr     (pci_ad[AW-1:0]),
    .base_pg  (win_base_pg),
    .limit_pg (win_limit_pg),
    .loc_off  (loc_offset),
    .hit      (win_hit),
    .xlat     (win_xlat)
  );

  pcitw_parity #(.DW(DW)) par_u (
    .ad       (pci_ad),
    .cbe_n    (pci_cbe_n),
    .par_lo   (pci_par),
    .par_hi   (pci_par64),
    .lane_bad (lane_bad)
  );

  pcitw_ctrl #(.AW(AW), .DW(DW), .BC_W(BC_W), .SPC_W(SPC_W)) ctrl_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (pci_frame_n),
    .irdy_n   (pci_irdy_n),
    .req64_n  (pci_req64_n),
    .ad       (pci_ad),
    .cbe_n    (pci_cbe_n),
    .hit      (win_hit),
    .xlat     (win_xlat),
    .lane_bad (lane_bad),
    .aq_ready (aq_ready),
    .dq_space (dq_space),
    .devsel_n (pci_devsel_n),
    .trdy_n   (pci_trdy_n),
    .stop_n   (pci_stop_n),
    .ack64_n  (pci_ack64_n),
    .perr_n   (pci_perr_n),
    .ape_evt  (ape_evt),
    .dpe_evt  (dpe_evt),
    .aq_valid (aq_valid),
    .aq_addr  (aq_addr),
    .aq_bytes (aq_bytes),
    .aq_wide  (aq_wide),
    .dq_valid (dq_valid),
    .dq_data  (dq_data),
    .dq_be    (dq_be)
  );
endmodule

// File: rtl/pcitw_chk.sv
module pcitw_chk (
  input logic clk,
  input logic rst_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ack64_n,
  input logic perr_n,
  input logic dq_valid,
  input logic aq_valid,
  input logic aq_ready,
  input logic ape_evt
);
  // R3
  beat_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> (!trdy_n && !devsel_n));
  // R5
  stop_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> (trdy_n && !devsel_n));
  // R5
  stop_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_n) |-> $past(dq_valid));
  // R4
  ack64_with_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack64_n |-> !devsel_n);
  // R7
  entry_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aq_valid |-> $past(dq_valid));
  // R7
  entry_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aq_valid |-> aq_ready);
  // R8
  perr_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(dq_valid));
  // R9
  apar_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ape_evt |-> devsel_n);
endmodule

bind pci_inwr_target pcitw_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .devsel_n (pci_devsel_n),
  .trdy_n   (pci_trdy_n),
  .stop_n   (pci_stop_n),
  .ack64_n  (pci_ack64_n),
  .perr_n   (pci_perr_n),
  .dq_valid (dq_valid),
  .aq_valid (aq_valid),
  .aq_ready (aq_ready),
  .ape_evt  (ape_evt)
);

// File: tb/pci_inwr_target_tb.sv
module pci_inwr_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, req64_n = 1'b1;
  logic [63:0] ad = '0;
  logic [7:0]  cbe_n = '1;
  logic        par = 1'b0, par64 = 1'b0;
  logic        devsel_n, trdy_n, stop_n, ack64_n, perr_n;
  logic [19:0] base_pg = 20'h00400, limit_pg = 20'h00403;
  logic [31:0] loc_off = 32'h8000_0000;
  logic        aq_valid, aq_ready = 1'b1, aq_wide;
  logic [31:0] aq_addr;
  logic [11:0] aq_bytes;
  logic        dq_valid;
  logic [63:0] dq_data;
  logic [7:0]  dq_be;
  logic [4:0]  dq_space = 5'd8;
  logic        ape_evt, dpe_evt;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pci_inwr_target dut_i (
    .clk(clk), .rst_n(rst_n),
    .pci_frame_n(frame_n), .pci_irdy_n(irdy_n), .pci_req64_n(req64_n),
    .pci_ad(ad), .pci_cbe_n(cbe_n), .pci_par(par), .pci_par64(par64),
    .pci_devsel_n(devsel_n), .pci_trdy_n(trdy_n), .pci_stop_n(stop_n),
    .pci_ack64_n(ack64_n), .pci_perr_n(perr_n),
    .win_base_pg(base_pg), .win_limit_pg(limit_pg), .loc_offset(loc_off),
    .aq_valid(aq_valid), .aq_ready(aq_ready), .aq_addr(aq_addr),
    .aq_bytes(aq_bytes), .aq_wide(aq_wide),
    .dq_valid(dq_valid), .dq_data(dq_data), .dq_be(dq_be), .dq_space(dq_space),
    .ape_evt(ape_evt), .dpe_evt(dpe_evt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit even_par(input logic [31:0] d, input logic [3:0] c);
    return ^{d, c};
  endfunction

  function automatic bit exp_claim(input logic [31:0] a, input logic [3:0] cmd,
                                   input bit bad_ap, input bit aqr, input int spc);
    return (cmd == 4'b0111) && (a[31:12] >= base_pg) && (a[31:12] <= limit_pg) &&
           !bad_ap && aqr && (spc != 0);
  endfunction

  task automatic idle_chk(input string req);
    chk(devsel_n && trdy_n && stop_n && ack64_n && perr_n, req, "idle pins",
        {59'd0, devsel_n, trdy_n, stop_n, ack64_n, perr_n}, 64'h1F);
    chk(!dq_valid && !aq_valid, req, "idle pushes", {62'd0, dq_valid, aq_valid}, 64'd0);
  endtask

  task automatic run_wr(input logic [31:0] addr, input logic [3:0] cmd, input bit wide,
                        input int len, input int spc, input bit aqr, input bit bad_ap,
                        input int bad_beat, input int waitpct);
    bit claim, fill, prev_bad, wt;
    int nexp, sent;
    logic [63:0] d;
    logic [7:0]  c;
    claim = exp_claim(addr, cmd, bad_ap, aqr, spc);
    @(posedge clk); #2;
    frame_n = 1'b1; irdy_n = 1'b1; dq_space = 5'(spc); aq_ready = aqr;
    @(posedge clk); #2;
    frame_n = 1'b0; irdy_n = 1'b1; req64_n = !wide;
    ad = {$urandom, addr}; cbe_n = {4'hF, cmd};
    par = even_par(addr, cmd) ^ bad_ap; par64 = 1'b0;
    @(negedge clk);
    idle_chk("R10");
    @(posedge clk); #2;
    if (!claim) begin
      frame_n = 1'b1; irdy_n = 1'b0; req64_n = 1'b1;
      @(negedge clk);
      chk(devsel_n == 1'b1, (bad_ap ? "R9" : (aqr && spc != 0) ? "R1" : "R2"),
          "unexpected claim", {63'd0, devsel_n}, 64'd1);
      chk(ape_evt == bad_ap, "R9", "ape_evt", {63'd0, ape_evt}, {63'd0, bad_ap});
      chk(!dq_valid, "R2", "push on unclaimed", {63'd0, dq_valid}, 64'd0);
      @(posedge clk); #2;
      irdy_n = 1'b1;
      @(negedge clk);
      idle_chk("R2");
      return;
    end
    nexp = (spc < len) ? spc : len;
    fill = (spc < len);
    sent = 0; prev_bad = 1'b0;
    while (sent < nexp) begin
      wt = ($urandom % 100) < waitpct;
      d = {$urandom, $urandom};
      c = 8'($urandom);
      irdy_n = wt; ad = d; cbe_n = c;
      frame_n = (!wt && sent == len - 1);
      par   = even_par(d[31:0], c[3:0]) ^ (!wt && sent == bad_beat);
      par64 = even_par(d[63:32], c[7:4]);
      @(negedge clk);
      chk(!devsel_n && !trdy_n && stop_n, "R3", "claimed pins",
          {61'd0, devsel_n, trdy_n, stop_n}, 64'd1);
      chk(ack64_n == !wide, "R4", "ack64", {63'd0, ack64_n}, {63'd0, !wide});
      chk(perr_n == !prev_bad, "R8", "perr", {63'd0, perr_n}, {63'd0, !prev_bad});
      chk(dq_valid == !wt, "R3", "beat push", {63'd0, dq_valid}, {63'd0, !wt});
      if (!wt) begin
        chk(dq_data == (wide ? d : {32'd0, d[31:0]}), "R4", "beat data", dq_data,
            wide ? d : {32'd0, d[31:0]});
        chk(dq_be == (wide ? ~c : {4'd0, ~c[3:0]}), "R4", "beat be", {56'd0, dq_be},
            {56'd0, (wide ? ~c : {4'd0, ~c[3:0]})});
      end
      prev_bad = !wt && (sent == bad_beat);
      if (!wt) sent++;
      @(posedge clk); #2;
      if (!wt) dq_space = dq_space - 5'd1;
    end
    irdy_n = 1'b1;
    frame_n = !fill;
    @(negedge clk);
    chk(aq_valid, "R7", "entry push", {63'd0, aq_valid}, 64'd1);
    chk(aq_addr == addr - {base_pg, 12'd0} + loc_off, "R7", "entry addr",
        {32'd0, aq_addr}, {32'd0, addr - {base_pg, 12'd0} + loc_off});
    chk(aq_bytes == 12'(nexp * (wide ? 8 : 4)), "R7", "entry bytes",
        {52'd0, aq_bytes}, 64'(nexp * (wide ? 8 : 4)));
    chk(aq_wide == wide, "R7", "entry width", {63'd0, aq_wide}, {63'd0, wide});
    chk(perr_n == !prev_bad && dpe_evt == prev_bad, "R8", "perr last",
        {62'd0, perr_n, dpe_evt}, {62'd0, !prev_bad, prev_bad});
    chk(!dq_valid, "R3", "no push after end", {63'd0, dq_valid}, 64'd0);
    if (fill) begin
      chk(!stop_n && trdy_n && !devsel_n, "R5", "disconnect",
          {61'd0, stop_n, trdy_n, devsel_n}, 64'd2);
      @(posedge clk); #2;
      frame_n = 1'b1; irdy_n = 1'b0;
      @(negedge clk);
      chk(!stop_n && !devsel_n, "R5", "stop held", {62'd0, stop_n, devsel_n}, 64'd0);
      @(posedge clk); #2;
      irdy_n = 1'b1;
      @(negedge clk);
      chk(stop_n && devsel_n, "R5", "stop release", {62'd0, stop_n, devsel_n}, 64'd3);
    end else begin
      chk(devsel_n && trdy_n && stop_n, "R6", "completion",
          {61'd0, devsel_n, trdy_n, stop_n}, 64'd7);
    end
    req64_n = 1'b1;
    @(posedge clk); #2;
    @(negedge clk);
    idle_chk("R10");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R10 watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'h5EED_0312));
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_chk("R10");
    rst_n = 1'b1;
    // directed corners
    run_wr(32'h0040_0010, 4'b0111, 1'b0, 3, 8, 1'b1, 1'b0, -1, 0);  // R3 R6 32-bit
    run_wr(32'h0040_1000, 4'b0111, 1'b1, 6, 2, 1'b1, 1'b0, -1, 0);  // R5 64-bit fill
    run_wr(32'h0040_0000, 4'b0111, 1'b1, 4, 4, 1'b1, 1'b0, -1, 0);  // R6 space==len, base edge R1
    run_wr(32'h0040_3FFC, 4'b0111, 1'b0, 2, 1, 1'b1, 1'b0, -1, 0);  // R5 single slot, limit edge R1
    run_wr(32'h003F_FFFC, 4'b0111, 1'b0, 2, 8, 1'b1, 1'b0, -1, 0);  // R1 below base
    run_wr(32'h0040_4000, 4'b0111, 1'b0, 2, 8, 1'b1, 1'b0, -1, 0);  // R1 above limit
    run_wr(32'h0040_0100, 4'b0110, 1'b0, 2, 8, 1'b1, 1'b0, -1, 0);  // R1 wrong command
    run_wr(32'h0040_0100, 4'b0111, 1'b0, 2, 8, 1'b0, 1'b0, -1, 0);  // R2 no address space
    run_wr(32'h0040_0100, 4'b0111, 1'b0, 2, 0, 1'b1, 1'b0, -1, 0);  // R2 no data space
    run_wr(32'h0040_0200, 4'b0111, 1'b0, 2, 8, 1'b1, 1'b1, -1, 0);  // R9
    run_wr(32'h0040_0300, 4'b0111, 1'b1, 5, 8, 1'b1, 1'b0, 2, 40);  // R8 mid-burst
    // random mix
    for (int i = 0; i < 80; i++) begin
      int sel;
      logic [19:0] pg;
      base_pg  = 20'h00100 + 20'($urandom % 20'h00F00);
      limit_pg = base_pg + 20'($urandom % 4);
      loc_off  = $urandom;
      sel = $urandom % 5;
      case (sel)
        0: pg = base_pg + 20'($urandom % (limit_pg - base_pg + 1));
        1: pg = base_pg;
        2: pg = limit_pg;
        3: pg = base_pg - 20'd1;
        default: pg = limit_pg + 20'd1;
      endcase
      a = {pg, (sel == 2) ? 12'hFFC : 12'($urandom) & 12'hFFC};
      run_wr(a, (($urandom % 10) != 0) ? 4'b0111 : 4'b0110, 1'($urandom),
             1 + int'($urandom % 10), int'($urandom % 9), (($urandom % 10) != 0),
             (($urandom % 20) == 0), (($urandom % 4) == 0) ? int'($urandom % 4) : -1, 30);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule